// File: doc/BRIEF.md
# Error-Flag Port Overwrite Controller

This block sits next to the error-detection packet generator of a serial video transmitter. It drives a narrow synchronous side port, five data lines wide, through which an external agent can inspect or replace the fifteen error flags and the two validity bits of the outgoing error-detection packet. A two-bit group select decides which five flags the port addresses. A direction input decides whether the port reads or writes.

In read mode, the block drives the selected group of final outgoing flags onto the port. In write mode, each clock edge captures the port data into a pending register for the selected group. Those values replace the flags of the next packet only. The packet-sent strobe clears every pending register. After that, the flags follow the host overwrite values where the host has enabled them, and otherwise the normally computed values. A port overwrite always beats a host overwrite of the same bit.

The final flag vector is `{ffv, apv, full-field group, active-picture group, ancillary group}`. Each group is laid out from bit 4 down to bit 0 as UES, IDA, IDH, EDA, EDH.

Top module: `edh_flagport_ctrl`

## Requirements
- R1: Select code 0 addresses the ancillary group (final vector bits 4:0). Code 1 addresses the active-picture group (bits 9:5). Code 2 addresses the full-field group (bits 14:10). Code 3 addresses the validity pair (bits 16:15). Inside each group, bit 4 is UES, then IDA, IDH and EDA, and bit 0 is EDH.
- R2: When `fp_dir_rd` is low, `fp_oe` is low and `fp_dout` is zero. When `fp_dir_rd` is high, `fp_oe` is high.
- R3: In read mode, `fp_dout` shows the current final outgoing flags of the selected group. For code 3 it shows `{3'b000, ffv, apv}`.
- R4: In write mode, a clock edge captures `fp_din` for the selected group. From the next cycle on, those values appear in `flags_out` until a packet-sent strobe releases them. A later write replaces an earlier one.
- R5: A packet-sent strobe with no write in the same cycle releases all pending groups. From the next cycle, `flags_out` equals the host value where `host_ovr_en` is set, and `flags_calc` elsewhere.
- R6: A write in the same cycle as the packet-sent strobe stays pending, so it applies to the following packet. Other groups are released by that strobe.
- R7: For each bit, the priority order is: pending port value first, then the host overwrite value, then the computed value.
- R8: A write with code 3 sets apv from `fp_din[0]` and ffv from `fp_din[1]`. `fp_din[4:2]` has no effect.
- R9: A write changes only the selected group. The other groups keep their current source.
- R10: After reset, no group is pending and `flags_out` is the host/computed merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_sel | input | 2 | Group select |
| fp_dir_rd | input | 1 | 1 = read, 0 = write |
| fp_din | input | 5 | Port write data |
| fp_dout | output | 5 | Port read data |
| fp_oe | output | 1 | Port output enable |
| host_ovr_en | input | 17 | Per-bit host overwrite enable |
| host_ovr_val | input | 17 | Host overwrite values |
| flags_calc | input | 17 | Normally computed flags |
| pkt_sent | input | 1 | One-cycle strobe: outgoing packet sent |
| flags_out | output | 17 | Final flags for the outgoing packet |

## Verification
The hardest case to reach is a port write that coincides with the packet-sent strobe while other groups are still pending. The write must survive and the other groups must be released on the same edge. A directed phase first fills several groups, then writes one group in the strobe cycle, and checks both outcomes on the next cycle. A long random phase follows. It biases the strobe and write-mode densities so that this collision, writes to the validity pair with junk in the upper data bits, and host enables overlapping pending bits all occur many times against the reference model.

// File: rtl/edh_fp_pkg.sv
package edh_fp_pkg;
  localparam int GRP_W     = 5;
  localparam int FLAG_GRPS = 3;
  localparam int VLD_W     = 2;
  localparam int SLOTS     = FLAG_GRPS + 1;
  localparam int SEL_W     = $clog2(SLOTS);
  localparam int FLAG_W    = FLAG_GRPS * GRP_W + VLD_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_ANC = 2'd0,
    SEL_AP  = 2'd1,
    SEL_FF  = 2'd2,
    SEL_VLD = 2'd3
  } fp_sel_e;

  function automatic int slot_width(input int s);
    return (s < FLAG_GRPS) ? GRP_W : VLD_W;
  endfunction
endpackage

// File: rtl/edh_fp_slot.sv
module edh_fp_slot #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         pkt_sent,
  input  logic [W-1:0] wr_data,
  output logic         pend,
  output logic [W-1:0] val
);
  logic pend_nxt;

  always_comb begin
    pend_nxt = pend;
    if (wr_en)         pend_nxt = 1'b1;
    else if (pkt_sent) pend_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val <= '0;
    else if (wr_en) val <= wr_data;
  end

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pend && val == $past(wr_data)));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && !wr_en) |=> !pend);
  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && wr_en) |=> pend);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !pkt_sent) |=> ($stable(pend) && $stable(val)));
endmodule

// File: rtl/edh_fp_merge.sv
module edh_fp_merge #(
  parameter int N = 17
) (
  input  logic [N-1:0] port_pend,
  input  logic [N-1:0] port_val,
  input  logic [N-1:0] host_en,
  input  logic [N-1:0] host_val,
  input  logic [N-1:0] calc,
  output logic [N-1:0] merged
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (port_pend[i])    merged[i] = port_val[i];
      else if (host_en[i]) merged[i] = host_val[i];
      else                 merged[i] = calc[i];
    end
  end
endmodule

// File: rtl/edh_fp_rdmux.sv
module edh_fp_rdmux
  import edh_fp_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic              dir_rd,
  input  logic [FLAG_W-1:0] flags,
  output logic [GRP_W-1:0]  dout,
  output logic              oe
);
  logic [GRP_W-1:0] padded [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_pad
    localparam int W = slot_width(s);
    localparam int B = s * GRP_W;
    if (W == GRP_W) begin : g_full
      assign padded[s] = flags[B +: W];
    end else begin : g_part
      assign padded[s] = {{(GRP_W-W){1'b0}}, flags[B +: W]};
    end
  end

  always_comb begin
    oe   = dir_rd;
    dout = dir_rd ? padded[sel] : '0;
  end
endmodule

// File: rtl/edh_flagport_ctrl.sv
module edh_flagport_ctrl
  import edh_fp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fp_sel,
  input  logic        fp_dir_rd,
  input  logic [4:0]  fp_din,
  output logic [4:0]  fp_dout,
  output logic        fp_oe,
  input  logic [16:0] host_ovr_en,
  input  logic [16:0] host_ovr_val,
  input  logic [16:0] flags_calc,
  input  logic        pkt_sent,
  output logic [16:0] flags_out
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [FLAG_W-1:0] pend_mask;
  logic [FLAG_W-1:0] port_vals;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int W = slot_width(s);
    localparam int B = s * GRP_W;
    logic         wr;
    logic         pend;
    logic [W-1:0] val;

    assign wr = !fp_dir_rd && (fp_sel == SEL_W'(s));

    edh_fp_slot #(.W(W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_en    (wr),
      .pkt_sent (pkt_sent),
      .wr_data  (fp_din[W-1:0]),
      .pend     (pend),
      .val      (val)
    );

    assign pend_mask[B +: W] = {W{pend}};
    assign port_vals[B +: W] = val;
  end

  edh_fp_merge #(.N(FLAG_W)) u_merge (
    .port_pend (pend_mask),
    .port_val  (port_vals),
    .host_en   (host_ovr_en),
    .host_val  (host_ovr_val),
    .calc      (flags_calc),
    .merged    (flags_out)
  );

  edh_fp_rdmux u_rdmux (
    .sel    (fp_sel),
    .dir_rd (fp_dir_rd),
    .flags  (flags_out),
    .dout   (fp_dout),
    .oe     (fp_oe)
  );

  assert_dir_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fp_dir_rd |-> fp_oe);
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fp_dir_rd |-> (!fp_oe && fp_dout == '0));
  assert_portwins_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!fp_dir_rd && fp_sel == SEL_ANC) |=> (flags_out[4:0] == $past(fp_din)));
  assert_vld_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!fp_dir_rd && fp_sel == SEL_VLD) |=> (flags_out[16:15] == $past(fp_din[1:0])));
  assert_free_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fp_dir_rd && pkt_sent) |=>
      (flags_out == ((host_ovr_en & host_ovr_val) | (~host_ovr_en & flags_calc))));
endmodule

// File: tb/edh_flagport_ctrl_test.sv
module edh_flagport_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [1:0]  fp_sel;
  logic        fp_dir_rd;
  logic [4:0]  fp_din;
  logic [4:0]  fp_dout;
  logic        fp_oe;
  logic [16:0] host_ovr_en;
  logic [16:0] host_ovr_val;
  logic [16:0] flags_calc;
  logic        pkt_sent;
  logic [16:0] flags_out;

  int checks;
  int fails;
  bit m_pend [4];
  logic [4:0] m_val [4];

  edh_flagport_ctrl uut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int base_of(input int s);
    return s * 5;
  endfunction

  function automatic int width_of(input int s);
    return (s == 3) ? 2 : 5;
  endfunction

  function automatic logic [16:0] exp_flags();
    logic [16:0] e;
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < width_of(s); k++) begin
        int i = base_of(s) + k;
        if (m_pend[s])          e[i] = m_val[s][k];
        else if (host_ovr_en[i]) e[i] = host_ovr_val[i];
        else                    e[i] = flags_calc[i];
      end
    return e;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic compare(input string req);
    logic [16:0] e;
    logic [4:0]  d;
    e = exp_flags();
    d = '0;
    if (fp_dir_rd) begin
      if (fp_sel == 2'd3) d = {3'b000, e[16:15]};
      else                d = e[fp_sel*5 +: 5];
    end
    check(req, "flags_out", flags_out, e);
    check(req, "fp_oe", {16'b0, fp_oe}, {16'b0, fp_dir_rd});
    check(req, "fp_dout", {12'b0, fp_dout}, {12'b0, d});
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    if (rst_n) begin
      if (pkt_sent) for (int s = 0; s < 4; s++) m_pend[s] = 1'b0;
      if (!fp_dir_rd) begin
        m_pend[fp_sel] = 1'b1;
        m_val[fp_sel]  = (fp_sel == 2'd3) ? {3'b000, fp_din[1:0]} : fp_din;
      end
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic wr(input logic [1:0] s, input logic [4:0] d, input logic p,
                    input string req);
    fp_dir_rd = 1'b0; fp_sel = s; fp_din = d; pkt_sent = p;
    tick(req);
    fp_dir_rd = 1'b1; pkt_sent = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic p, input string req);
    fp_dir_rd = 1'b1; fp_sel = s; pkt_sent = p;
    tick(req);
    pkt_sent = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    checks = 0; fails = 0;
    for (int s = 0; s < 4; s++) begin m_pend[s] = 1'b0; m_val[s] = '0; end
    rst_n = 1'b0; fp_sel = '0; fp_dir_rd = 1'b1; fp_din = '0; pkt_sent = 1'b0;
    host_ovr_en = '0; host_ovr_val = '0; flags_calc = 17'h0A5C3;
    repeat (3) @(negedge clk);
    compare("R10");
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) rd(2'(c), 1'b0, "R10");

    // read of each group with a distinct computed pattern (R1, R3)
    flags_calc = 17'h1B2C4;
    for (int c = 0; c < 4; c++) rd(2'(c), 1'b0, "R3");
    flags_calc = 17'h04E1F;
    for (int c = 0; c < 4; c++) rd(2'(c), 1'b0, "R1");

    // write ancillary group, hold until strobe (R4)
    wr(2'd0, 5'b10110, 1'b0, "R4");
    rd(2'd0, 1'b0, "R4");
    wr(2'd0, 5'b01001, 1'b0, "R4");
    rd(2'd0, 1'b0, "R4");
    // direction outputs in write mode (R2)
    fp_dir_rd = 1'b0; fp_sel = 2'd0; fp_din = 5'b01001;
    @(negedge clk); #1;
    check("R2", "fp_oe write", {16'b0, fp_oe}, 17'h0);
    check("R2", "fp_dout write", {12'b0, fp_dout}, 17'h0);
    tick("R2");
    fp_dir_rd = 1'b1;
    rd(2'd0, 1'b1, "R5");
    rd(2'd0, 1'b0, "R5");

    // host overwrite and port precedence (R7)
    host_ovr_en = 17'h1FFFF; host_ovr_val = 17'h15555;
    rd(2'd1, 1'b0, "R7");
    wr(2'd1, 5'b11111, 1'b0, "R7");
    rd(2'd1, 1'b0, "R7");
    rd(2'd1, 1'b1, "R7");
    rd(2'd1, 1'b0, "R7");
    host_ovr_en = 17'h0F0F0;

    // write affects only selected group (R9)
    wr(2'd2, 5'b00111, 1'b0, "R9");
    rd(2'd0, 1'b0, "R9");
    rd(2'd1, 1'b0, "R9");
    rd(2'd2, 1'b0, "R9");

    // validity pair with junk in upper bits (R8)
    wr(2'd3, 5'b11110, 1'b0, "R8");
    rd(2'd3, 1'b0, "R8");
    wr(2'd3, 5'b00001, 1'b0, "R8");
    rd(2'd3, 1'b0, "R8");

    // write colliding with strobe while others pending (R6)
    wr(2'd0, 5'b11000, 1'b0, "R6");
    wr(2'd1, 5'b00011, 1'b1, "R6");
    rd(2'd1, 1'b0, "R6");
    rd(2'd0, 1'b0, "R6");
    rd(2'd1, 1'b1, "R5");
    rd(2'd1, 1'b0, "R5");

    // random mix (R1)
    for (int n = 0; n < 4000; n++) begin
      fp_sel       = 2'($urandom);
      fp_dir_rd    = ($urandom % 3) != 0;
      fp_din       = 5'($urandom);
      pkt_sent     = ($urandom % 4) == 0;
      host_ovr_en  = 17'($urandom);
      host_ovr_val = 17'($urandom);
      flags_calc   = 17'($urandom);
      tick("R1");
    end
    summary();
  end
endmodule